// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers one-cycle cause pulses from internal sources into a 32-bit status word that the host can read. The host acknowledges a cause by writing a 1 to its status bit. A separate enable word selects which status bits may drive the host interrupt line. The block does not raise the line as soon as a cause arrives. A hold-off counter, advanced by an external 32-microsecond tick, delays the line until a programmable number of ticks has passed since an enabled cause first became pending. A high-priority receive cause at bit 30 skips the hold-off.

A second counter on the same tick injects a periodic receive cause into bit 28 at a programmable interval. The host reaches three words through a small register port (address 0: status, address 1: enable, address 2: timing). The timing word holds the hold-off length in bits 7:0 (reset 0x40, which is 2048 microseconds), the periodic interval in bits 15:8 (0 turns it off, 0xFF gives about 8 ms) and the hold-off mode switch in bit 31.

Top module: `irqc_top`

## Requirements
- R1: After reset the status word reads 0, the enable word reads 0, the timing word at address 2 reads 0x8000_0040 and irq_o is low.
- R2: A 1 on cause_i[n] sets status bit n at the next clock edge. The bit stays set until the host clears it, whether or not it is enabled.
- R3: A write to address 0 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R4: If a cause sets a bit in the same cycle that the host writes 1 to that bit, the bit ends up set. Other bits written 1 in that cycle are cleared.
- R5: A status bit whose enable bit (address 1, same position) is 0 never drives irq_o, however many ticks pass.
- R6: With timing bit 31 = 1 and a hold-off length V > 0, irq_o rises at the clock edge that samples the V-th tick_i pulse counted after an enabled cause became pending. Ticks in the cycle that sets the status bit are not counted. Idle cycles without a tick never raise irq_o.
- R7: With a hold-off length of 0, or with timing bit 31 = 0, irq_o is high in the cycle after an enabled status bit is set.
- R8: An enabled status bit 30 drives irq_o high at once, whatever the hold-off state.
- R9: irq_o falls once no enabled status bit remains. The next enabled cause restarts the hold-off count from zero.
- R10: With a periodic interval P > 0 (timing bits 15:8), status bit 28 is set on every P-th tick since the last write to the timing word. With P = 0 it is never set by the timer.
- R11: The timing word stores only bits 31 and 15:0. All its other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_i | input | 32 | Cause pulses, one bit per status position |
| tick_i | input | 1 | One-cycle pulse every 32 microseconds |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 status, 1 enable, 2 timing) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register, combinational |
| irq_o | output | 1 | Host interrupt line |

## Verification
A source can set a status bit in the same cycle that the host writes 1 to acknowledge it. The bench provokes this by raising cause_i bit 1 in the same cycle as a status write of 0x42, where bit 6 is already pending. It then reads the status word and expects 0x2: the new cause survives and the stale one is cleared. The periodic timer firing against host clears is also exercised: bit 28 is acknowledged between two timer hits and must reappear exactly P ticks later.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam int TIME_W = 8;
    localparam int ADDR_W = 2;

    localparam int BIT_HOLD_MODE = 31;
    localparam int BIT_BYPASS    = 30;
    localparam int BIT_PERIODIC  = 28;

    localparam int PERIOD_LSB = TIME_W;
    localparam int WINDOW_LSB = 0;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 2'd0,
        RA_ENABLE = 2'd1,
        RA_TIMING = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              hold_mode;
        logic [TIME_W-1:0] period;
        logic [TIME_W-1:0] window;
    } timing_cfg_t;

    localparam timing_cfg_t TIMING_RESET = '{
        hold_mode: 1'b1,
        period:    '0,
        window:    8'h40
    };

    function automatic logic [DATA_W-1:0] pack_timing(input timing_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BIT_HOLD_MODE] = c.hold_mode;
        w[PERIOD_LSB +: TIME_W] = c.period;
        w[WINDOW_LSB +: TIME_W] = c.window;
        return w;
    endfunction

    function automatic timing_cfg_t unpack_timing(input logic [DATA_W-1:0] w);
        timing_cfg_t c;
        c.hold_mode = w[BIT_HOLD_MODE];
        c.period    = w[PERIOD_LSB +: TIME_W];
        c.window    = w[WINDOW_LSB +: TIME_W];
        return c;
    endfunction

endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] enable_q,
    output timing_cfg_t       timing_q,
    output logic              timing_wr,
    output logic [DATA_W-1:0] rdata
);

    reg_addr_e         sel;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] status_d;

    assign sel       = reg_addr_e'(addr);
    assign clr_vec   = (we && sel == RA_STATUS) ? wdata : '0;
    assign timing_wr = we && sel == RA_TIMING;

    // a source set in the same cycle as an acknowledge keeps the bit
    assign status_d = (status_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
            timing_q <= TIMING_RESET;
        end else begin
            status_q <= status_d;
            if (we && sel == RA_ENABLE)
                enable_q <= wdata;
            if (timing_wr)
                timing_q <= unpack_timing(wdata);
        end
    end

    always_comb begin
        case (sel)
            RA_STATUS: rdata = status_q;
            RA_ENABLE: rdata = enable_q;
            RA_TIMING: rdata = pack_timing(timing_q);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqc_periodic.sv
module irqc_periodic
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              restart,
    input  logic [TIME_W-1:0] period,
    output logic              hit
);

    logic [TIME_W-1:0] pcnt;
    logic [TIME_W:0]   pcnt_inc;
    logic              active;

    assign active   = period != '0;
    assign pcnt_inc = {1'b0, pcnt} + 1'b1;
    assign hit      = tick_i && active && !restart && (pcnt_inc >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            pcnt <= '0;
        end else if (tick_i) begin
            if (hit)
                pcnt <= '0;
            else
                pcnt <= pcnt_inc[TIME_W-1:0];
        end
    end

endmodule

// File: rtl/irqc_holdoff.sv
module irqc_holdoff
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              pending,
    input  logic [TIME_W-1:0] window,
    output logic              expired
);

    logic [TIME_W-1:0] cnt;
    logic [TIME_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !pending) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (!expired && tick_i) begin
            if (cnt_inc >= {1'b0, window})
                expired <= 1'b1;
            else
                cnt <= cnt_inc[TIME_W-1:0];
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] cause_i,
    input  logic              tick_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] enable_q;
    timing_cfg_t       timing_q;
    logic              timing_wr;
    logic              periodic_hit;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] live;
    logic              pending;
    logic              expired;
    logic              immediate;

    always_comb begin
        set_vec = cause_i;
        set_vec[BIT_PERIODIC] = cause_i[BIT_PERIODIC] | periodic_hit;
    end

    irqc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .set_vec   (set_vec),
        .status_q  (status_q),
        .enable_q  (enable_q),
        .timing_q  (timing_q),
        .timing_wr (timing_wr),
        .rdata     (reg_rdata)
    );

    irqc_periodic u_periodic (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .restart (timing_wr),
        .period  (timing_q.period),
        .hit     (periodic_hit)
    );

    assign live    = status_q & enable_q;
    assign pending = |live;

    irqc_holdoff u_holdoff (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .pending (pending),
        .window  (timing_q.window),
        .expired (expired)
    );

    assign immediate = live[BIT_BYPASS] || !timing_q.hold_mode || (timing_q.window == '0);
    assign irq_o     = pending && (immediate || expired);

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] cause_i,
    input logic              tick_i,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_o,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] enable_q,
    input timing_cfg_t       timing_q
);

    logic [DATA_W-1:0] ack_mask;
    assign ack_mask = (reg_we && reg_addr == 2'd0) ? reg_wdata : '0;

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(cause_i)) == $past(cause_i)));

    assert_clear_only_by_ack_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & ~status_q & ~$past(ack_mask)) == '0));

    assert_irq_needs_enabled_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|(status_q & enable_q)));

    assert_bypass_now_R8: assert property (@(posedge clk) disable iff (rst)
        (status_q[BIT_BYPASS] && enable_q[BIT_BYPASS]) |-> irq_o);

    assert_holdoff_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_o) && timing_q.hold_mode && timing_q.window != '0
         && !(status_q[BIT_BYPASS] && enable_q[BIT_BYPASS])) |-> $past(tick_i));

endmodule

bind irqc_top irqc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cause_i   (cause_i),
    .tick_i    (tick_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .timing_q  (timing_q)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cause_i = '0;
    logic        tick_i = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    always #10 clk = ~clk;

    irqc_top uut (
        .clk       (clk),
        .rst       (rst),
        .cause_i   (cause_i),
        .tick_i    (tick_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        while (sb_q.size() > 0) begin
            it  = sb_q.pop_front();
            act = it.is_rd ? reg_rdata : {31'b0, irq_o};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_chk(input bit is_rd, input logic [31:0] exp, input string tag);
        item_t it;
        it.is_rd = is_rd;
        it.exp   = exp;
        it.tag   = tag;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic chk_irq(input bit v, input string tag);
        push_chk(1'b0, {31'b0, v}, tag);
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        push_chk(1'b1, exp, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [31:0] m);
        cause_i = m;
        step();
        cause_i = '0;
    endtask

    task automatic tick();
        tick_i = 1'b1;
        step();
        tick_i = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        chk_rd(2'd0, 32'h0, "R1 status reset");
        chk_rd(2'd1, 32'h0, "R1 enable reset");
        chk_rd(2'd2, 32'h8000_0040, "R1 timing reset");

        // R11 only bits 31 and 15:0 kept
        wr(2'd2, 32'hFFFF_FFFF);
        chk_rd(2'd2, 32'h8000_FFFF, "R11 timing readback");
        wr(2'd2, 32'h8000_0003);

        // R2 / R5 disabled cause latches but stays silent
        pulse(32'h0000_0008);
        chk_rd(2'd0, 32'h0000_0008, "R2 status latched");
        repeat (5) tick();
        chk_irq(1'b0, "R5 disabled cause ignored");

        // R3 write-one-to-clear
        wr(2'd0, 32'h0);
        chk_rd(2'd0, 32'h0000_0008, "R3 zero write keeps");
        wr(2'd0, 32'h0000_0008);
        chk_rd(2'd0, 32'h0, "R3 one write clears");

        // R6 hold-off of three ticks
        wr(2'd1, 32'hFFFF_FFFF);
        pulse(32'h0000_0001);
        chk_irq(1'b0, "R6 no irq before ticks");
        tick(); tick();
        chk_irq(1'b0, "R6 no irq after two ticks");
        repeat (3) step();
        chk_irq(1'b0, "R6 idle cycles do not count");
        tick();
        chk_irq(1'b1, "R6 irq on third tick");

        // R9 drop and restart
        wr(2'd0, 32'h0000_0001);
        chk_irq(1'b0, "R9 irq drops after clear");
        pulse(32'h0200_0000);
        tick(); tick();
        chk_irq(1'b0, "R9 count restarted");
        tick();
        chk_irq(1'b1, "R9 irq after full window");
        wr(2'd0, 32'h0200_0000);
        chk_irq(1'b0, "R9 irq low again");

        // R4 set and clear in the same cycle
        pulse(32'h0000_0040);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0000_0042; cause_i = 32'h0000_0002;
        step();
        reg_we = 1'b0; reg_wdata = '0; cause_i = '0;
        chk_rd(2'd0, 32'h0000_0002, "R4 set wins over clear");
        wr(2'd0, 32'h0000_0002);
        chk_rd(2'd0, 32'h0, "R4 cleared afterwards");

        // R7 zero window and mode off
        wr(2'd2, 32'h8000_0000);
        pulse(32'h0000_0080);
        chk_irq(1'b1, "R7 zero window immediate");
        wr(2'd0, 32'h0000_0080);
        chk_irq(1'b0, "R7 cleared");
        wr(2'd2, 32'h0000_0040);
        pulse(32'h2000_0000);
        chk_irq(1'b1, "R7 mode off immediate");
        wr(2'd0, 32'h2000_0000);
        chk_irq(1'b0, "R7 cleared mode off");

        // R8 bypass cause
        wr(2'd2, 32'h8000_0040);
        pulse(32'h4000_0000);
        chk_irq(1'b1, "R8 bypass immediate");
        wr(2'd0, 32'h4000_0000);
        chk_irq(1'b0, "R8 bypass cleared");
        wr(2'd1, 32'hBFFF_FFFF);
        pulse(32'h4000_0000);
        chk_irq(1'b0, "R8 disabled bypass silent");
        chk_rd(2'd0, 32'h4000_0000, "R2 disabled bypass latched");
        wr(2'd0, 32'h4000_0000);

        // R10 periodic cause every three ticks
        wr(2'd1, 32'h1000_0000);
        wr(2'd2, 32'h8000_0300);
        tick(); tick();
        chk_rd(2'd0, 32'h0, "R10 not before third tick");
        tick();
        chk_rd(2'd0, 32'h1000_0000, "R10 periodic set");
        chk_irq(1'b1, "R10 periodic irq");
        wr(2'd0, 32'h1000_0000);
        tick(); tick();
        chk_rd(2'd0, 32'h0, "R10 second period pending");
        tick();
        chk_rd(2'd0, 32'h1000_0000, "R10 periodic again");
        wr(2'd0, 32'h1000_0000);
        wr(2'd2, 32'h8000_0000);
        repeat (6) tick();
        chk_rd(2'd0, 32'h0, "R10 zero period off");

        finished = 1;
        summary();
        $finish;
    end

endmodule